// File: doc/BRIEF.md
# Frame-Sync Serial Data Master

This block is the host end of a serial port for multichannel converters in which the bit clock never stops and each frame is marked only by a pulse on a separate sync line. From the master clock it derives a bit clock at 1, 1/2, 1/4 or 1/8 of the master frequency. It counts out frames of 256 or 2560 master clocks and raises the frame-sync line once per frame. The line rises one master clock before a bit-clock rising edge and stays high for one bit period.

After each sync pulse the block samples the receive line on bit-clock rising edges. It gathers a configurable number (1 to 8) of back-to-back 24-bit words, most significant bit first. It presents each word together with its channel index and a one-cycle valid strobe. A transmit shifter sends a host word in each of the same slots, so the block can feed the data input of the first device in a daisy chain. If the requested words do not fit in one frame, a configuration-error flag is raised and both capture and transmit stay idle.

Top module: `fsync_serial_master`

## Requirements
- R1: While `div_sel` = d, the bit clock has a period of exactly 2^d master clocks and runs without pause. With d = 0 it follows the master clock. With d >= 1 it is high for the first half of each period and low for the second half.
- R2: Rising edges of `fsync` are spaced exactly 256 master clocks apart when `long_frame` = 0 and 2560 when `long_frame` = 1.
- R3: `fsync` rises exactly one master clock before a bit-clock rising edge and stays high for one bit period (2^d master clocks).
- R4: Receive bits are sampled on bit-clock rising edges. The first rising edge after `fsync` rises samples bit 23 of word 0. Each following rising edge samples the next lower bit, and word k+1 starts directly after bit 0 of word k.
- R5: With `nchan_m1` = n-1, each frame yields exactly n words on `word_data`, indexed 0, 1, ..., n-1 on `word_chan`. Each word is marked by `word_valid` high for a single master-clock cycle.
- R6: `cfg_err` is 1 when n*24 exceeds the bit periods in a frame (frame length >> `div_sel`), and 0 otherwise. While it is 1, `word_valid` and `sdo` stay 0.
- R7: In each of the n word slots, `sdo` carries `tx_word` MSB first. Each bit holds for one whole bit period, starting at the bit-clock rising edge of that bit's slot, so it is stable at the falling edge. Outside the slots `sdo` is 0.
- R8: During reset `fsync`, `word_valid`, `sdo` and `cfg_err` are 0.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | active-low synchronous reset |
| div_sel | input | 2 | bit-clock divider: ratio 2^div_sel |
| long_frame | input | 1 | 0: 256-clock frame, 1: 2560-clock frame |
| nchan_m1 | input | 3 | number of words per frame minus one |
| sdi | input | 1 | serial data from the device data-out line |
| tx_word | input | 24 | word transmitted in every slot |
| bclk | output | 1 | bit clock |
| fsync | output | 1 | frame-sync pulse |
| sdo | output | 1 | serial data toward a downstream data-in line |
| word_data | output | 24 | last captured word |
| word_chan | output | 3 | channel index of `word_data` |
| word_valid | output | 1 | one-cycle strobe for a new word |
| cfg_err | output | 1 | channel count does not fit the frame |

## Verification
The assertions assume that `div_sel`, `long_frame`, `nchan_m1` and `tx_word` are held steady whenever reset is released. Their spacing counters and the error-quiet check would not hold across a configuration change in mid-frame. The bench changes the configuration only while reset is asserted and then lets several whole frames run. Its device model changes `sdi` only on bit-clock falling edges, and it starts shifting only after the first rising edge that follows a sync pulse. The receive line is therefore never moving at the edge where the block samples it.

// File: rtl/fsync_serial_pkg.sv
package fsync_serial_pkg;

    typedef enum logic {
        FRAME_SHORT = 1'b0,
        FRAME_LONG  = 1'b1
    } frame_sel_e;

    // frame length in master clocks for the selected mode
    function automatic int unsigned frame_clocks(input frame_sel_e sel,
                                                 input int unsigned short_len,
                                                 input int unsigned long_len);
        return (sel == FRAME_LONG) ? long_len : short_len;
    endfunction

endpackage

// File: rtl/fsd_timebase.sv
module fsd_timebase
    import fsync_serial_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int DIV_W     = 2,
    parameter int SHORT_LEN = 256,
    parameter int LONG_LEN  = 2560
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             long_frame,
    output logic             bclk_reg,
    output logic             fsync,
    output logic             rise_evt,
    output logic             frame_first
);

    typedef struct packed {
        logic [CNT_W-1:0] fcnt;
        logic             bclk;
        logic             fsync;
    } tb_state_t;

    tb_state_t st_q, st_d;

    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] phase;

    always_comb begin
        ratio = CNT_W'(1) << div_sel;
        half  = ratio >> 1;
        len   = CNT_W'(frame_clocks(frame_sel_e'(long_frame), SHORT_LEN, LONG_LEN));
        st_d  = st_q;

        // master-clock position inside the frame
        if (st_q.fcnt >= len - CNT_W'(1))
            st_d.fcnt = '0;
        else
            st_d.fcnt = st_q.fcnt + CNT_W'(1);

        phase = st_d.fcnt & (ratio - CNT_W'(1));

        // divided bit clock: high in the first half of each bit period
        st_d.bclk = (div_sel == '0) ? 1'b1 : (phase < half);

        // sync goes high one clock before the rising edge at fcnt==0,
        // then holds for the rest of one bit period
        if (st_d.fcnt == len - CNT_W'(1))
            st_d.fsync = 1'b1;
        else
            st_d.fsync = st_q.fsync && (st_d.fcnt < ratio - CNT_W'(1));

        rise_evt    = (phase == '0);
        frame_first = (st_d.fcnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.fcnt  <= '0;
            st_q.bclk  <= 1'b1;
            st_q.fsync <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk_reg = st_q.bclk;
    assign fsync    = st_q.fsync;

endmodule

// File: rtl/fsd_cfg_guard.sv
module fsd_cfg_guard
    import fsync_serial_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int DIV_W     = 2,
    parameter int CH_W      = 3,
    parameter int WORD_W    = 24,
    parameter int SHORT_LEN = 256,
    parameter int LONG_LEN  = 2560
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             long_frame,
    input  logic [CH_W-1:0]  nchan_m1,
    output logic             cfg_err
);

    logic             err_d, err_q;
    logic [CNT_W:0]   need_bits;
    logic [CNT_W:0]   avail_bits;

    always_comb begin
        need_bits  = (CNT_W+1)'((32'(nchan_m1) + 32'd1) * 32'(WORD_W));
        avail_bits = (CNT_W+1)'(frame_clocks(frame_sel_e'(long_frame), SHORT_LEN, LONG_LEN)) >> div_sel;
        err_d      = (need_bits > avail_bits);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign cfg_err = err_q;

endmodule

// File: rtl/fsd_slot_seq.sv
module fsd_slot_seq #(
    parameter int WORD_W = 24,
    parameter int CH_W   = 3,
    parameter int BIT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_evt,
    input  logic             frame_first,
    input  logic             cfg_err,
    input  logic [CH_W-1:0]  nchan_m1,
    output logic             slot_go,
    output logic [BIT_W-1:0] slot_bit,
    output logic [CH_W-1:0]  slot_chan
);

    typedef struct packed {
        logic             active;
        logic [BIT_W-1:0] bitn;
        logic [CH_W-1:0]  chan;
    } seq_state_t;

    seq_state_t sq_q, sq_d;

    logic             cur_active;
    logic [BIT_W-1:0] cur_bit;
    logic [CH_W-1:0]  cur_chan;

    always_comb begin
        // a frame start re-arms the sequence from word 0, bit 23
        cur_active = frame_first ? !cfg_err : sq_q.active;
        cur_bit    = frame_first ? '0 : sq_q.bitn;
        cur_chan   = frame_first ? '0 : sq_q.chan;

        slot_go   = rise_evt && cur_active;
        slot_bit  = cur_bit;
        slot_chan = cur_chan;

        sq_d = sq_q;
        if (rise_evt) begin
            sq_d.active = cur_active;
            sq_d.bitn   = cur_bit;
            sq_d.chan   = cur_chan;
            if (cur_active) begin
                if (cur_bit == BIT_W'(WORD_W - 1)) begin
                    sq_d.bitn = '0;
                    if (cur_chan == nchan_m1)
                        sq_d.active = 1'b0;
                    else
                        sq_d.chan = cur_chan + CH_W'(1);
                end else begin
                    sq_d.bitn = cur_bit + BIT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q.active <= 1'b0;
            sq_q.bitn   <= '0;
            sq_q.chan   <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

endmodule

// File: rtl/fsd_rx.sv
module fsd_rx #(
    parameter int WORD_W = 24,
    parameter int CH_W   = 3,
    parameter int BIT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_go,
    input  logic [BIT_W-1:0]  slot_bit,
    input  logic [CH_W-1:0]   slot_chan,
    input  logic              sdi,
    output logic [WORD_W-1:0] word_data,
    output logic [CH_W-1:0]   word_chan,
    output logic              word_valid
);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] data;
        logic [CH_W-1:0]   chan;
        logic              valid;
    } rx_state_t;

    rx_state_t rx_q, rx_d;

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        if (slot_go) begin
            rx_d.shreg = {rx_q.shreg[WORD_W-2:0], sdi};
            if (slot_bit == BIT_W'(WORD_W - 1)) begin
                rx_d.data  = {rx_q.shreg[WORD_W-2:0], sdi};
                rx_d.chan  = slot_chan;
                rx_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q.shreg <= '0;
            rx_q.data  <= '0;
            rx_q.chan  <= '0;
            rx_q.valid <= 1'b0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign word_data  = rx_q.data;
    assign word_chan  = rx_q.chan;
    assign word_valid = rx_q.valid;

endmodule

// File: rtl/fsd_tx.sv
module fsd_tx #(
    parameter int WORD_W = 24,
    parameter int BIT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_evt,
    input  logic              slot_go,
    input  logic [BIT_W-1:0]  slot_bit,
    input  logic [WORD_W-1:0] tx_word,
    output logic              sdo
);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic              sdo;
    } tx_state_t;

    tx_state_t tx_q, tx_d;

    always_comb begin
        tx_d = tx_q;
        if (rise_evt) begin
            if (slot_go) begin
                if (slot_bit == '0) begin
                    tx_d.sdo   = tx_word[WORD_W-1];
                    tx_d.shreg = {tx_word[WORD_W-2:0], 1'b0};
                end else begin
                    tx_d.sdo   = tx_q.shreg[WORD_W-1];
                    tx_d.shreg = {tx_q.shreg[WORD_W-2:0], 1'b0};
                end
            end else begin
                tx_d.sdo = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q.shreg <= '0;
            tx_q.sdo   <= 1'b0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign sdo = tx_q.sdo;

endmodule

// File: rtl/fsync_serial_master.sv
module fsync_serial_master #(
    parameter int WORD_W    = 24,
    parameter int MAX_CH    = 8,
    parameter int SHORT_LEN = 256,
    parameter int LONG_LEN  = 2560,
    parameter int DIV_W     = 2,
    parameter bit HAS_TX    = 1'b1,
    parameter int CH_W      = $clog2(MAX_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic              long_frame,
    input  logic [CH_W-1:0]   nchan_m1,
    input  logic              sdi,
    input  logic [WORD_W-1:0] tx_word,
    output logic              bclk,
    output logic              fsync,
    output logic              sdo,
    output logic [WORD_W-1:0] word_data,
    output logic [CH_W-1:0]   word_chan,
    output logic              word_valid,
    output logic              cfg_err
);

    localparam int CNT_W = $clog2(LONG_LEN + 1);
    localparam int BIT_W = $clog2(WORD_W);

    logic             bclk_reg;
    logic             rise_evt;
    logic             frame_first;
    logic             slot_go;
    logic [BIT_W-1:0] slot_bit;
    logic [CH_W-1:0]  slot_chan;

    fsd_timebase #(
        .CNT_W(CNT_W), .DIV_W(DIV_W),
        .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)
    ) timebase_i (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .long_frame(long_frame),
        .bclk_reg(bclk_reg), .fsync(fsync),
        .rise_evt(rise_evt), .frame_first(frame_first)
    );

    // ratio 1: the bit clock is the master clock itself
    assign bclk = (div_sel == '0) ? clk : bclk_reg;

    fsd_cfg_guard #(
        .CNT_W(CNT_W), .DIV_W(DIV_W), .CH_W(CH_W), .WORD_W(WORD_W),
        .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)
    ) guard_i (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .long_frame(long_frame),
        .nchan_m1(nchan_m1), .cfg_err(cfg_err)
    );

    fsd_slot_seq #(
        .WORD_W(WORD_W), .CH_W(CH_W), .BIT_W(BIT_W)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .frame_first(frame_first),
        .cfg_err(cfg_err), .nchan_m1(nchan_m1),
        .slot_go(slot_go), .slot_bit(slot_bit), .slot_chan(slot_chan)
    );

    fsd_rx #(
        .WORD_W(WORD_W), .CH_W(CH_W), .BIT_W(BIT_W)
    ) rx_i (
        .clk(clk), .rst_n(rst_n), .slot_go(slot_go), .slot_bit(slot_bit),
        .slot_chan(slot_chan), .sdi(sdi),
        .word_data(word_data), .word_chan(word_chan), .word_valid(word_valid)
    );

    generate
        if (HAS_TX) begin : g_tx
            fsd_tx #(
                .WORD_W(WORD_W), .BIT_W(BIT_W)
            ) tx_i (
                .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .slot_go(slot_go),
                .slot_bit(slot_bit), .tx_word(tx_word), .sdo(sdo)
            );
        end else begin : g_no_tx
            logic unused_tx;
            assign unused_tx = ^tx_word;
            assign sdo       = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/fsync_serial_master_chk.sv
module fsync_serial_master_chk #(
    parameter int DIV_W     = 2,
    parameter int CH_W      = 3,
    parameter int SHORT_LEN = 256,
    parameter int LONG_LEN  = 2560
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_sel,
    input logic             long_frame,
    input logic [CH_W-1:0]  nchan_m1,
    input logic             bclk,
    input logic             fsync,
    input logic             sdo,
    input logic             word_valid,
    input logic [CH_W-1:0]  word_chan,
    input logic             cfg_err
);

    localparam int CW = $clog2(LONG_LEN + 1) + 1;

    logic          fs_prev, fs_seen;
    logic [CW-1:0] fs_cnt;
    logic          bk_prev, bk_seen;
    logic [CW-1:0] bk_cnt;
    logic          bk_cur;
    logic          fs_rise, bk_tog;
    logic [CW-1:0] fs_len, bk_half;

    assign bk_cur  = (div_sel != '0) ? bclk : 1'b1;
    assign fs_rise = fsync && !fs_prev;
    assign bk_tog  = (bk_cur != bk_prev);
    assign fs_len  = long_frame ? CW'(LONG_LEN) : CW'(SHORT_LEN);
    assign bk_half = (CW'(1) << div_sel) >> 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_prev <= 1'b0;
            fs_seen <= 1'b0;
            fs_cnt  <= '0;
            bk_prev <= 1'b1;
            bk_seen <= 1'b0;
            bk_cnt  <= '0;
        end else begin
            fs_prev <= fsync;
            bk_prev <= bk_cur;
            if (fs_rise) begin
                fs_cnt  <= CW'(1);
                fs_seen <= 1'b1;
            end else begin
                fs_cnt <= fs_cnt + CW'(1);
            end
            if (bk_tog) begin
                bk_cnt  <= CW'(1);
                bk_seen <= 1'b1;
            end else begin
                bk_cnt <= bk_cnt + CW'(1);
            end
        end
    end

    assert_bclk_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel != '0 && bk_seen && bk_tog) |-> (bk_cnt == bk_half));

    assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_seen && fs_rise) |-> (fs_cnt == fs_len));

    assert_fsync_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel != '0 && $rose(fsync)) |-> !bclk);

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    assert_chan_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (word_chan <= nchan_m1));

    assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!word_valid && !sdo));

endmodule

bind fsync_serial_master fsync_serial_master_chk #(
    .DIV_W(DIV_W), .CH_W(CH_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)
) chk_i (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .long_frame(long_frame),
    .nchan_m1(nchan_m1), .bclk(bclk), .fsync(fsync), .sdo(sdo),
    .word_valid(word_valid), .word_chan(word_chan), .cfg_err(cfg_err)
);

// File: tb/fsync_serial_master_tb_top.sv
`timescale 1ns/1ps
module fsync_serial_master_tb_top;

    localparam int TCK = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  div_sel = '0;
    logic        long_frame = 1'b0;
    logic [2:0]  nchan_m1 = '0;
    logic        sdi = 1'b0;
    logic [23:0] tx_word = '0;
    logic        bclk, fsync, sdo, word_valid, cfg_err;
    logic [23:0] word_data;
    logic [2:0]  word_chan;

    fsync_serial_master dut_i (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .long_frame(long_frame),
        .nchan_m1(nchan_m1), .sdi(sdi), .tx_word(tx_word),
        .bclk(bclk), .fsync(fsync), .sdo(sdo), .word_data(word_data),
        .word_chan(word_chan), .word_valid(word_valid), .cfg_err(cfg_err)
    );

    always #(TCK/2) clk = ~clk;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 0;

    // expected configuration, set by run_cfg
    int  e_ratio = 1;
    int  e_len = 256;
    int  e_words = 1;
    bit  e_err = 0;

    // device model and monitor state
    int      frame_no = 0;
    int      bitk = 0;
    int      words_seen = 0;
    bit      started = 0;
    bit      want_rise = 0;
    longint  t_fs = 0;
    longint  t_rise = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [23:0] pat(input int fr, input int ch);
        return 24'(fr * 24'h0731) ^ 24'(ch * 24'h1A5B3) ^ 24'hC35A96;
    endfunction

    function automatic logic dev_bit(input int fr, input int k);
        int w;
        logic [23:0] v;
        w = k / 24;
        v = pat(fr, w);
        return (w < 8) ? v[23 - (k % 24)] : 1'b0;
    endfunction

    // frame sync: frame count, spacing (R2), device restart
    always @(posedge fsync) begin
        if (rst_n) begin
            if (frame_no >= 1) begin
                check(($time - t_fs) == longint'(e_len * TCK), "R2 fsync spacing",
                      $time - t_fs, e_len * TCK);
                check(words_seen == e_words, "R5 words per frame", words_seen, e_words);
            end
            t_fs       = $time;
            want_rise  = 1;
            frame_no   = frame_no + 1;
            words_seen = 0;
            bitk       = 0;
            started    = 0;
            sdi        = dev_bit(frame_no, 0);
        end
    end

    // R3: width of the sync pulse
    always @(negedge fsync) begin
        if (rst_n && frame_no >= 1)
            check(($time - t_fs) == longint'(e_ratio * TCK), "R3 fsync width",
                  $time - t_fs, e_ratio * TCK);
    end

    // R1 bit-clock period, R3 sync lead
    always @(posedge bclk) begin
        if (rst_n) begin
            if (t_rise != 0)
                check(($time - t_rise) == longint'(e_ratio * TCK), "R1 bclk period",
                      $time - t_rise, e_ratio * TCK);
            t_rise = $time;
            if (want_rise && $time > t_fs) begin
                check(($time - t_fs) == longint'(TCK), "R3 fsync lead", $time - t_fs, TCK);
                want_rise = 0;
            end
            if (frame_no >= 1) started = 1;
        end
    end

    // device shifts on falling edges; R7 sdo sampled where a receiver would
    always @(negedge bclk) begin
        if (rst_n && started) begin
            if (!e_err && bitk < e_words * 24)
                check(sdo == tx_word[23 - (bitk % 24)], "R7 sdo bit", sdo,
                      tx_word[23 - (bitk % 24)]);
            else
                check(sdo == 1'b0, "R7/R6 sdo idle", sdo, 0);
            bitk = bitk + 1;
            sdi  = dev_bit(frame_no, bitk);
        end
    end

    // R4/R5 captured words
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            check(frame_no >= 1 && !e_err, "R6 no word when err", word_valid, 0);
            check(word_chan == 3'(words_seen), "R5 channel index", word_chan, words_seen);
            check(word_data == pat(frame_no, words_seen), "R4 word data", word_data,
                  pat(frame_no, words_seen));
            words_seen = words_seen + 1;
        end
    end

    task automatic run_cfg(input int d, input int lf, input int nm1, input int nfr, input int idx);
        @(negedge clk);
        rst_n      = 1'b0;
        div_sel    = 2'(d);
        long_frame = lf[0];
        nchan_m1   = 3'(nm1);
        tx_word    = 24'hB4D21E ^ 24'(idx * 24'h0F1357);
        e_ratio    = 1 << d;
        e_len      = lf ? 2560 : 256;
        e_words    = nm1 + 1;
        e_err      = (e_words * 24) > (e_len / e_ratio);
        if (e_err) e_words = 0;
        frame_no   = 0;
        started    = 0;
        want_rise  = 0;
        t_rise     = 0;
        t_fs       = 0;
        words_seen = 0;
        sdi        = 1'b0;
        repeat (3) @(negedge clk);
        // R8 reset state
        check(fsync == 1'b0,      "R8 fsync in reset", fsync, 0);
        check(word_valid == 1'b0, "R8 valid in reset", word_valid, 0);
        check(sdo == 1'b0,        "R8 sdo in reset", sdo, 0);
        check(cfg_err == 1'b0,    "R8 err in reset", cfg_err, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(cfg_err == e_err, "R6 cfg_err value", cfg_err, e_err);
        wait (frame_no == nfr + 1);
        @(negedge clk);
    endtask

    initial begin
        run_cfg(0, 0, 7, 3, 0);
        run_cfg(1, 0, 4, 3, 1);
        run_cfg(2, 0, 1, 3, 2);
        run_cfg(3, 0, 0, 3, 3);
        run_cfg(3, 0, 1, 2, 4);   // 48 bits > 32 available: error
        run_cfg(2, 0, 2, 2, 5);   // 72 bits > 64 available: error
        run_cfg(1, 0, 0, 2, 6);
        run_cfg(0, 1, 7, 2, 7);
        run_cfg(1, 1, 7, 2, 8);
        run_cfg(2, 1, 7, 2, 9);
        run_cfg(3, 1, 7, 2, 10);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(190000 * TCK);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", frame_no, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule